// File: doc/BRIEF.md
# Linked PWM Ramp Timing Matrix

This block holds four digital PWM ramp counters. Each counter can run on its own, or it can be restarted by an event from a chosen source. The source can be another channel's sync event or an edge on an external sync pin. Restarting one channel from another lets the channels be chained, so that the phase offsets between power stages stay fixed. The external pin passes through a two-flop synchronizer and a rising-edge detector before any channel can use it.

Each channel has the following settings:
- a period and a duty compare, both double-buffered and taken up when the counter restarts;
- a restart delay used for internal sources;
- a separate restart delay used for the external source;
- a lead value that places a one-clock sample strobe shortly before the end of the period.

A shared selector sends one channel's sync events to a sync-out pin. A combinational error flag reports when two channels that follow the same internal source have different delays. All settings are written through a single-cycle register write port.

Top module: `pwm_sync_matrix`

## Requirements
- R1: After reset, `pwm_out`, `sync_out` and `cfg_err` are all low.
- R2: A free-running channel with period P (field 0) pulses `sync_evt` for one clock every P clocks. The counter runs 0..P-1, and `sync_evt` is high in the cycle where the count is 0.
- R3: `pwm_out` is high while the count is below the active duty value (field 1). A duty of D gives D high cycles per period, starting at the `sync_evt` cycle.
- R4: Writes to period and duty do not change the running period. They take effect from the next counter restart.
- R5: `samp_trig` pulses when count = P − L − 1. L is the programmed lead (field 4), raised to MIN_LEAD (default 57 clocks) if it is smaller.
- R6: With an internal source code k (field 5, codes 1..4 select channels 0..3) and phase delay d (field 2), the channel's `sync_evt` follows the source's `sync_evt` by exactly 1 + d clocks.
- R7: With source code 5, a rising edge on `ext_sync_in`, driven just after clock edge n, restarts the channel so that `sync_evt` is high at cycle n + 3 + e. Here e is the external delay (field 3), and the phase delay is not used.
- R8: When external edges stop, an externally synced channel falls back to wrapping at its programmed period.
- R9: A source write is accepted only for codes 0..5 and only when the code does not name the channel itself. Any other value stores 0 (free-run). Only wr_data[2:0] is decoded.
- R10: Sync-out select (field 6, channel index ignored) uses these codes: 0 = off, 1..4 = channels 0..3, anything else = off. `sync_out` equals the selected channel's `sync_evt`, or 0 when off.
- R11: `cfg_err` is high exactly when two channels have the same internal source code (1..4) but different phase delays. Channels sharing the external source never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 2 | Target channel of the write |
| wr_field | input | 3 | Field: 0 period, 1 duty, 2 phase delay, 3 ext delay, 4 lead, 5 source, 6 sync-out select |
| wr_data | input | 16 | Write data |
| ext_sync_in | input | 1 | Asynchronous external sync |
| pwm_out | output | 4 | PWM outputs, one per channel |
| samp_trig | output | 4 | Sample strobes |
| sync_evt | output | 4 | One-clock restart pulses |
| sync_out | output | 1 | Selected channel's sync event |
| cfg_err | output | 1 | Delay mismatch among same-source channels |

## Verification
The hardest state to reach is a channel whose count is locked to the external pin while it still holds a longer period of its own. From the ports, that needs a steady train of edges arriving faster than the programmed wrap. The bench drives edges every 150 clocks into a channel programmed for 200. It measures the restart latency only from the second edge onward, when the lock is certain. It then stops the edges and times the next natural wrap. Chained channels are checked the same way, after several periods of the source, by measuring the gap between the two channels' sync events.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [2:0] {
    FLD_PERIOD  = 3'd0,
    FLD_DUTY    = 3'd1,
    FLD_PHASE   = 3'd2,
    FLD_EXTDLY  = 3'd3,
    FLD_LEAD    = 3'd4,
    FLD_SRC     = 3'd5,
    FLD_SYNCOUT = 3'd6
  } fld_e;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
    logic [CNT_W-1:0] phase;
    logic [CNT_W-1:0] extd;
    logic [CNT_W-1:0] lead;
    logic [SEL_W-1:0] src;
  } chan_cfg_t;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_pulse = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R7: an edge gives exactly one pulse
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/ramp_chan.sv
module ramp_chan #(
  parameter int unsigned CW         = 16,
  parameter int unsigned MIN_LEAD   = 57,
  parameter int unsigned RST_PERIOD = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] per_shadow,
  input  logic [CW-1:0] duty_shadow,
  input  logic [CW-1:0] dly_val,
  input  logic [CW-1:0] lead_val,
  input  logic          trig,
  output logic          pwm,
  output logic          samp,
  output logic          evt
);
  logic [CW-1:0] cnt_q, cnt_d, per_q, per_d, duty_q, duty_d, dcnt_q, dcnt_d, lead_eff;
  logic          armed_q, armed_d, evt_q;
  logic          last, dly_fire, dly_now, restart;

  always_comb begin
    last     = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, per_q};
    dly_fire = armed_q && (dcnt_q == CW'(1));
    dly_now  = trig && (dly_val == '0);
    restart  = last || dly_fire || dly_now;

    cnt_d  = restart ? '0 : cnt_q + CW'(1);
    per_d  = restart ? per_shadow  : per_q;
    duty_d = restart ? duty_shadow : duty_q;

    armed_d = armed_q;
    dcnt_d  = dcnt_q;
    if (trig && dly_val != '0) begin
      armed_d = 1'b1;
      dcnt_d  = dly_val;
    end else if (dly_fire || dly_now) begin
      armed_d = 1'b0;
      dcnt_d  = '0;
    end else if (armed_q) begin
      dcnt_d  = dcnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= CW'(RST_PERIOD);
      duty_q  <= '0;
      dcnt_q  <= '0;
      armed_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      duty_q  <= duty_d;
      dcnt_q  <= dcnt_d;
      armed_q <= armed_d;
      evt_q   <= restart;
    end
  end

  assign lead_eff = (lead_val < CW'(MIN_LEAD)) ? CW'(MIN_LEAD) : lead_val;
  assign samp = (({2'b0, cnt_q} + {2'b0, lead_eff} + (CW+2)'(1)) == {2'b0, per_q});
  assign pwm  = cnt_q < duty_q;
  assign evt  = evt_q;

  // R2: a sync event always marks count zero
  assert_evt_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> (cnt_q == '0));
  // R4: active period only changes at a restart
  assert_period_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_q |-> $stable(per_q));
  // R6: an armed delay never sits at zero
  assert_dly_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (dcnt_q != '0));
endmodule

// File: rtl/pwm_sync_matrix.sv
module pwm_sync_matrix
  import pwm_sync_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter int unsigned MIN_LEAD   = 57,
  parameter int unsigned RST_PERIOD = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NCH)-1:0]   wr_chan,
  input  logic [2:0]               wr_field,
  input  logic [CNT_W-1:0]         wr_data,
  input  logic                     ext_sync_in,
  output logic [NCH-1:0]           pwm_out,
  output logic [NCH-1:0]           samp_trig,
  output logic [NCH-1:0]           sync_evt,
  output logic                     sync_out,
  output logic                     cfg_err
);
  localparam int unsigned CW   = CNT_W;
  localparam int unsigned CH_W = $clog2(NCH);
  localparam logic [SEL_W-1:0] SRC_EXT = SEL_W'(NCH + 1);

  logic [1:0]       rst_q;
  logic             rst_s;
  chan_cfg_t        cfg_q [NCH];
  chan_cfg_t        cfg_d [NCH];
  logic [SEL_W-1:0] so_q, so_d, cand;
  logic             ext_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  sync_edge_det #(.STAGES(2)) u_ext (
    .clk(clk), .rst_n(rst_s), .async_in(ext_sync_in), .rise_pulse(ext_pulse)
  );

  always_comb begin
    so_d = so_q;
    cand = wr_data[SEL_W-1:0];
    for (int i = 0; i < NCH; i++) cfg_d[i] = cfg_q[i];
    if (wr_en) begin
      if (wr_field == FLD_SYNCOUT) begin
        so_d = (cand > SEL_W'(NCH)) ? '0 : cand;
      end else begin
        for (int i = 0; i < NCH; i++) begin
          if (wr_chan == CH_W'(i)) begin
            case (wr_field)
              FLD_PERIOD: cfg_d[i].period = wr_data;
              FLD_DUTY:   cfg_d[i].duty   = wr_data;
              FLD_PHASE:  cfg_d[i].phase  = wr_data;
              FLD_EXTDLY: cfg_d[i].extd   = wr_data;
              FLD_LEAD:   cfg_d[i].lead   = wr_data;
              FLD_SRC:    cfg_d[i].src    = (cand > SRC_EXT || cand == SEL_W'(i + 1)) ? '0 : cand;
              default:    cfg_d[i].src    = cfg_q[i].src;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      so_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        cfg_q[i].period <= CW'(RST_PERIOD);
        cfg_q[i].duty   <= '0;
        cfg_q[i].phase  <= '0;
        cfg_q[i].extd   <= '0;
        cfg_q[i].lead   <= '0;
        cfg_q[i].src    <= '0;
      end
    end else begin
      so_q <= so_d;
      for (int i = 0; i < NCH; i++) cfg_q[i] <= cfg_d[i];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          trig_i;
    logic [CW-1:0] dly_i;

    always_comb begin
      trig_i = 1'b0;
      dly_i  = cfg_q[i].phase;
      if (cfg_q[i].src == SRC_EXT) begin
        trig_i = ext_pulse;
        dly_i  = cfg_q[i].extd;
      end else begin
        for (int j = 0; j < NCH; j++)
          if (cfg_q[i].src == SEL_W'(j + 1)) trig_i = sync_evt[j];
      end
    end

    ramp_chan #(.CW(CW), .MIN_LEAD(MIN_LEAD), .RST_PERIOD(RST_PERIOD)) u_ch (
      .clk(clk), .rst_n(rst_s),
      .per_shadow(cfg_q[i].period), .duty_shadow(cfg_q[i].duty),
      .dly_val(dly_i), .lead_val(cfg_q[i].lead), .trig(trig_i),
      .pwm(pwm_out[i]), .samp(samp_trig[i]), .evt(sync_evt[i])
    );

    // R9: a channel never follows its own event
    assert_src_not_self_R9: assert property (@(posedge clk) disable iff (!rst_s)
      cfg_q[i].src != SEL_W'(i + 1));
  end

  always_comb begin
    sync_out = 1'b0;
    for (int j = 0; j < NCH; j++)
      if (so_q == SEL_W'(j + 1)) sync_out = sync_evt[j];
  end

  always_comb begin
    cfg_err = 1'b0;
    for (int i = 0; i < NCH; i++)
      for (int j = i + 1; j < NCH; j++)
        if (cfg_q[i].src == cfg_q[j].src && cfg_q[i].src != '0 &&
            cfg_q[i].src != SRC_EXT && cfg_q[i].phase != cfg_q[j].phase)
          cfg_err = 1'b1;
  end
endmodule

// File: tb/sim_pwm_sync_matrix.sv
module sim_pwm_sync_matrix;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_chan;
  logic [2:0]  wr_field;
  logic [15:0] wr_data;
  logic        ext_sync_in;
  logic [3:0]  pwm_out, samp_trig, sync_evt;
  logic        sync_out, cfg_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_sync_matrix u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_field(wr_field), .wr_data(wr_data), .ext_sync_in(ext_sync_in),
    .pwm_out(pwm_out), .samp_trig(samp_trig), .sync_evt(sync_evt),
    .sync_out(sync_out), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input int ch, input int fld, input int data);
    wr_en = 1'b1; wr_chan = 2'(ch); wr_field = 3'(fld); wr_data = 16'(data);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_evt(input int ch, input int lim, output int at);
    at = -1;
    for (int n = 0; n < lim; n++) begin
      @(posedge clk); @(negedge clk);
      if (sync_evt[ch]) begin at = cyc; break; end
    end
  endtask

  task automatic t_reset;
    chk(pwm_out == 4'b0, "R1 pwm_out", int'(pwm_out), 0);
    chk(sync_out == 1'b0, "R1 sync_out", int'(sync_out), 0);
    chk(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);
  endtask

  task automatic t_freerun;
    int a, b, c;
    wr(0, 0, 100);
    wr(1, 0, 150);
    wait_evt(0, 80, a);
    wait_evt(0, 120, a);
    wait_evt(0, 120, b);
    chk(b - a == 100, "R2 period ch0", b - a, 100);
    wait_evt(1, 200, c);
    wait_evt(1, 200, a);
    wait_evt(1, 200, b);
    chk(b - a == 150, "R2 period ch1", b - a, 150);
  endtask

  task automatic t_pwm;
    int a, hi;
    wr(0, 1, 30);
    wait_evt(0, 120, a);
    wait_evt(0, 120, a);
    hi = 0;
    for (int n = 0; n < 100; n++) begin
      if (pwm_out[0]) hi++;
      step(1);
    end
    chk(hi == 30, "R3 duty high count", hi, 30);
  endtask

  task automatic t_dbuf;
    int a, b, hi;
    a = cyc;
    step(10);
    wr(0, 1, 70);
    wr(0, 0, 120);
    step(45 - (cyc - a));
    chk(pwm_out[0] == 1'b0, "R4 old duty kept", int'(pwm_out[0]), 0);
    wait_evt(0, 130, b);
    chk(b - a == 100, "R4 old period kept", b - a, 100);
    hi = 0;
    for (int n = 0; n < 120; n++) begin
      if (pwm_out[0]) hi++;
      step(1);
    end
    chk(hi == 70, "R4 new duty", hi, 70);
    chk(sync_evt[0] == 1'b1, "R4 new period", int'(sync_evt[0]), 1);
  endtask

  task automatic t_lead;
    int a, s;
    wait_evt(0, 130, a);
    s = -1;
    for (int n = 0; n < 120; n++) begin
      step(1);
      if (samp_trig[0]) begin s = cyc; break; end
    end
    chk(s - a == 62, "R5 lead clamped", s - a, 62);
    wr(0, 4, 80);
    wait_evt(0, 130, a);
    s = -1;
    for (int n = 0; n < 120; n++) begin
      step(1);
      if (samp_trig[0]) begin s = cyc; break; end
    end
    chk(s - a == 39, "R5 lead 80", s - a, 39);
  endtask

  task automatic t_chain;
    int a, b;
    wr(1, 0, 120);
    wr(1, 2, 5);
    wr(1, 5, 1);
    for (int k = 0; k < 3; k++) wait_evt(0, 130, a);
    wait_evt(0, 130, a);
    wait_evt(1, 20, b);
    chk(b - a == 6, "R6 lag delay 5", b - a, 6);
    wr(1, 2, 0);
    for (int k = 0; k < 2; k++) wait_evt(0, 130, a);
    wait_evt(0, 130, a);
    wait_evt(1, 20, b);
    chk(b - a == 1, "R6 lag delay 0", b - a, 1);
  endtask

  task automatic t_ext;
    int c0, at, last_at;
    wr(2, 0, 200);
    wr(2, 3, 4);
    wr(2, 2, 9);
    wr(2, 5, 5);
    step(210);
    last_at = 0;
    for (int p = 0; p < 3; p++) begin
      ext_sync_in = 1'b1;
      c0 = cyc;
      wait_evt(2, 20, at);
      ext_sync_in = 1'b0;
      if (p > 0) chk(at - c0 == 7, "R7 ext restart latency", at - c0, 7);
      last_at = at;
      step(150 - (cyc - c0));
    end
    wait_evt(2, 250, at);
    chk(at - last_at == 200, "R8 fallback wrap", at - last_at, 200);
  endtask

  task automatic t_self;
    int a, b;
    wr(3, 0, 90);
    wr(3, 2, 3);
    wr(3, 5, 4);
    wait_evt(3, 100, a);
    wait_evt(3, 100, a);
    wait_evt(3, 100, b);
    chk(b - a == 90, "R9 self source rejected", b - a, 90);
    wr(3, 5, 7);
    wait_evt(3, 100, a);
    wait_evt(3, 100, b);
    chk(b - a == 90, "R9 invalid code rejected", b - a, 90);
  endtask

  task automatic t_syncout;
    int mism, pulses;
    wr(0, 6, 2);
    mism = 0; pulses = 0;
    for (int n = 0; n < 300; n++) begin
      if (sync_out != sync_evt[1]) mism++;
      if (sync_out) pulses++;
      step(1);
    end
    chk(mism == 0, "R10 follows ch1", mism, 0);
    chk(pulses >= 2, "R10 pulses seen", pulses, 2);
    wr(0, 6, 6);
    pulses = 0;
    for (int n = 0; n < 300; n++) begin
      if (sync_out) pulses++;
      step(1);
    end
    chk(pulses == 0, "R10 invalid code off", pulses, 0);
    wr(0, 6, 0);
    pulses = 0;
    for (int n = 0; n < 300; n++) begin
      if (sync_out) pulses++;
      step(1);
    end
    chk(pulses == 0, "R10 disabled", pulses, 0);
  endtask

  task automatic t_cfgerr;
    wr(3, 2, 3);
    chk(cfg_err == 1'b0, "R11 no share", int'(cfg_err), 0);
    wr(3, 5, 1);
    chk(cfg_err == 1'b1, "R11 mismatch flagged", int'(cfg_err), 1);
    wr(3, 2, 0);
    chk(cfg_err == 1'b0, "R11 equal delays", int'(cfg_err), 0);
    wr(3, 3, 2);
    wr(3, 5, 5);
    chk(cfg_err == 1'b0, "R11 ext share ignored", int'(cfg_err), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_chan = '0; wr_field = '0; wr_data = '0;
    ext_sync_in = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_freerun();
    t_pwm();
    t_dbuf();
    t_lead();
    t_chain();
    t_ext();
    t_self();
    t_syncout();
    t_cfgerr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule